// File: doc/BRIEF.md
# Instruction Word and Operand Mode Decoder

This block takes the first 16-bit word of an instruction for a small 16-bit register machine and splits it into fields. It reports the opcode and flags the special-format instruction class. It decodes the two operand specifiers into an addressing-mode class, a register index, an inline literal where the operand has one, and a flag that says whether the operand needs an extra word from the instruction stream. From the two operands it also computes the instruction length in words and the number of extra cycles that operand lookup costs.

The decoder is purely combinational, so every output is valid in the same cycle as the input word. A fetch unit uses the length to step the program counter. An execute stage uses the modes and register indices to route its operands. Special instructions, which have an opcode field of zero, are only flagged: their second field is not treated as an operand.

Top module: `instr_decoder`

## Requirements
- R1: `opcode` equals instruction bits 4:0. `is_special` is 1 exactly when those bits are zero. The second operand code (b) is bits 9:5 and the first operand code (a) is bits 15:10.
- R2: Operand codes 0x00–0x07 give mode 0 (register direct), with the register index equal to the code's low three bits (order A,B,C,X,Y,Z,I,J = 0..7) and no extra word.
- R3: Codes 0x08–0x0f give mode 1 (memory through register), with the register index equal to the low three bits and no extra word.
- R4: Codes 0x10–0x17 give mode 2 (memory at register plus next word), with the register index equal to the low three bits and an extra word.
- R5: Code 0x18 gives mode 3 (push, pre-decrement stack pointer) in operand b and mode 4 (pop, post-increment) in operand a. Neither needs an extra word.
- R6: Code 0x19 gives mode 5 (memory at stack pointer) with no extra word. Code 0x1a gives mode 6 (stack pointer plus next word) with an extra word.
- R7: Codes 0x1b, 0x1c and 0x1d give modes 7, 8 and 9 (stack pointer, program counter, overflow register), none needing an extra word.
- R8: Code 0x1e gives mode 10 (memory at next word) and code 0x1f gives mode 11 (next word as a literal). Both need an extra word.
- R9: Operand a codes 0x20–0x3f give mode 12 (inline literal) with `a_lit` equal to the code minus 0x21 modulo 2^16, so 0x20 gives 0xffff and 0x3f gives 0x001e. Operand b never reports mode 12.
- R10: The register index is 0 for every mode other than 0, 1 and 2. `a_lit` is 0 for every mode other than 12.
- R11: `length` equals 1 plus the number of operands that need an extra word (range 1..3). `cycles` equals that same number of extra words.
- R12: When `is_special` is 1, operand b reads as mode 0, index 0, no extra word, and it does not add to `length` or `cycles`. Operand a is still decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 16 | First word of the instruction |
| opcode | output | 5 | Opcode field |
| is_special | output | 1 | Opcode field is zero |
| a_mode | output | 4 | Addressing mode of operand a |
| a_reg | output | 3 | Register index of operand a |
| a_lit | output | 16 | Inline literal of operand a |
| a_next | output | 1 | Operand a needs a next word |
| b_mode | output | 4 | Addressing mode of operand b |
| b_reg | output | 3 | Register index of operand b |
| b_next | output | 1 | Operand b needs a next word |
| length | output | 2 | Instruction length in words |
| cycles | output | 2 | Operand lookup cycle cost |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 5-bit opcode, a 5-bit operand b and a 6-bit operand a. With these values the whole input space is only 65536 words, so the bench applies every one of them and compares each against a behavioural model. This covers every mode in both operand positions, both ends of the inline literal range, and every special-instruction word.

// File: rtl/dec_pkg.sv
package dec_pkg;

    typedef enum logic [3:0] {
        MODE_REG        = 4'd0,
        MODE_REG_IND    = 4'd1,
        MODE_REG_OFS    = 4'd2,
        MODE_PUSH       = 4'd3,
        MODE_POP        = 4'd4,
        MODE_PEEK       = 4'd5,
        MODE_PICK       = 4'd6,
        MODE_SP         = 4'd7,
        MODE_PC         = 4'd8,
        MODE_EX         = 4'd9,
        MODE_ABS        = 4'd10,
        MODE_IMM_NEXT   = 4'd11,
        MODE_IMM_INLINE = 4'd12
    } opmode_e;

    typedef struct packed {
        opmode_e     mode;
        logic [2:0]  regidx;
        logic [15:0] lit;
        logic        next;
    } operand_t;

endpackage

// File: rtl/operand_decoder.sv
module operand_decoder
    import dec_pkg::*;
#(
    parameter bit          IS_A     = 1'b1,
    parameter int          CODE_W   = 6,
    parameter logic [15:0] LIT_BIAS = 16'h0021
) (
    input  logic [CODE_W-1:0] code,
    output operand_t          opnd
);
    localparam int GRP_W = CODE_W - 3;

    logic [5:0]       code6;
    logic [2:0]       low3;
    logic [GRP_W-1:0] grp;
    logic             in_lit_range;

    assign low3 = code[2:0];
    assign grp  = code[CODE_W-1:3];

    generate
        if (CODE_W >= 6) begin : g_wide
            assign code6        = code[5:0];
            assign in_lit_range = code[5];
        end else begin : g_narrow
            assign code6        = {{(6-CODE_W){1'b0}}, code};
            assign in_lit_range = 1'b0;
        end
    endgenerate

    logic [3:0] grp4;
    assign grp4 = {{(4-GRP_W+((GRP_W>4)?GRP_W:0)){1'b0}}, grp}[3:0];

    always_comb begin
        operand_t opnd_d;
        opnd_d = '{mode: MODE_REG, regidx: 3'd0, lit: 16'd0, next: 1'b0};
        if (in_lit_range) begin
            opnd_d.mode = MODE_IMM_INLINE;
            opnd_d.lit  = {10'd0, code6} - LIT_BIAS;
        end else begin
            unique case (code6[4:3])
                2'd0: begin
                    opnd_d.mode   = MODE_REG;
                    opnd_d.regidx = low3;
                end
                2'd1: begin
                    opnd_d.mode   = MODE_REG_IND;
                    opnd_d.regidx = low3;
                end
                2'd2: begin
                    opnd_d.mode   = MODE_REG_OFS;
                    opnd_d.regidx = low3;
                    opnd_d.next   = 1'b1;
                end
                default: begin
                    unique case (low3)
                        3'd0: opnd_d.mode = IS_A ? MODE_POP : MODE_PUSH;
                        3'd1: opnd_d.mode = MODE_PEEK;
                        3'd2: begin
                            opnd_d.mode = MODE_PICK;
                            opnd_d.next = 1'b1;
                        end
                        3'd3: opnd_d.mode = MODE_SP;
                        3'd4: opnd_d.mode = MODE_PC;
                        3'd5: opnd_d.mode = MODE_EX;
                        3'd6: begin
                            opnd_d.mode = MODE_ABS;
                            opnd_d.next = 1'b1;
                        end
                        default: begin
                            opnd_d.mode = MODE_IMM_NEXT;
                            opnd_d.next = 1'b1;
                        end
                    endcase
                end
            endcase
        end
        opnd = opnd_d;
    end

    logic unused_grp;
    assign unused_grp = ^grp4;

    always_comb begin
        if (opnd.mode != MODE_REG && opnd.mode != MODE_REG_IND && opnd.mode != MODE_REG_OFS)
            assert_regidx_zero_R10: assert (opnd.regidx == 3'd0)
                else $error("register index set for non-register mode");
    end

endmodule

// File: rtl/length_unit.sv
module length_unit #(
    parameter int LEN_W = 2
) (
    input  logic             a_next,
    input  logic             b_next,
    output logic [LEN_W-1:0] length,
    output logic [LEN_W-1:0] cycles
);
    logic [LEN_W-1:0] extra_d;

    always_comb begin
        extra_d = '0;
        if (a_next) extra_d = extra_d + 1'b1;
        if (b_next) extra_d = extra_d + 1'b1;
    end

    assign cycles = extra_d;
    assign length = extra_d + 1'b1;

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import dec_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int OPC_W  = 5,
    parameter int B_W    = 5,
    parameter int A_W    = 6
) (
    input  logic [WORD_W-1:0] instr_word,
    output logic [OPC_W-1:0]  opcode,
    output logic              is_special,
    output logic [3:0]        a_mode,
    output logic [2:0]        a_reg,
    output logic [15:0]       a_lit,
    output logic              a_next,
    output logic [3:0]        b_mode,
    output logic [2:0]        b_reg,
    output logic              b_next,
    output logic [1:0]        length,
    output logic [1:0]        cycles
);
    localparam int B_LSB = OPC_W;
    localparam int A_LSB = OPC_W + B_W;

    operand_t opa, opb;
    logic     b_next_eff;

    assign opcode     = instr_word[OPC_W-1:0];
    assign is_special = (instr_word[OPC_W-1:0] == '0);

    operand_decoder #(.IS_A(1'b1), .CODE_W(A_W)) u_opa (
        .code (instr_word[A_LSB +: A_W]),
        .opnd (opa)
    );

    operand_decoder #(.IS_A(1'b0), .CODE_W(B_W)) u_opb (
        .code (instr_word[B_LSB +: B_W]),
        .opnd (opb)
    );

    assign a_mode = opa.mode;
    assign a_reg  = opa.regidx;
    assign a_lit  = opa.lit;
    assign a_next = opa.next;

    always_comb begin
        if (is_special) begin
            b_mode     = MODE_REG;
            b_reg      = 3'd0;
            b_next_eff = 1'b0;
        end else begin
            b_mode     = opb.mode;
            b_reg      = opb.regidx;
            b_next_eff = opb.next;
        end
    end
    assign b_next = b_next_eff;

    logic [15:0] unused_blit;
    assign unused_blit = opb.lit;

    length_unit #(.LEN_W(2)) u_len (
        .a_next (opa.next),
        .b_next (b_next_eff),
        .length (length),
        .cycles (cycles)
    );

    always_comb begin
        assert_len_R11: assert (length == 2'd1 + {1'b0, a_next} + {1'b0, b_next})
            else $error("length does not match next-word flags");
        assert_cyc_R11: assert (cycles + 2'd1 == length)
            else $error("cycle cost does not match length");
        assert_b_no_inline_R9: assert (b_mode != MODE_IMM_INLINE)
            else $error("operand b reported inline literal");
        if (a_mode != MODE_IMM_INLINE)
            assert_lit_zero_R10: assert (a_lit == 16'd0)
                else $error("literal set outside inline mode");
        if (is_special)
            assert_special_R12: assert (!b_next && b_mode == MODE_REG)
                else $error("operand b active in special instruction");
    end

endmodule

// File: tb/sim_instr_decoder.sv
module sim_instr_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr_word = 16'd0;
    logic [4:0]  opcode;
    logic        is_special;
    logic [3:0]  a_mode, b_mode;
    logic [2:0]  a_reg, b_reg;
    logic [15:0] a_lit;
    logic        a_next, b_next;
    logic [1:0]  length, cycles;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 0;

    always #5 clk = ~clk;

    instr_decoder u0 (
        .instr_word (instr_word),
        .opcode     (opcode),
        .is_special (is_special),
        .a_mode     (a_mode),
        .a_reg      (a_reg),
        .a_lit      (a_lit),
        .a_next     (a_next),
        .b_mode     (b_mode),
        .b_reg      (b_reg),
        .b_next     (b_next),
        .length     (length),
        .cycles     (cycles)
    );

    // behavioural model of one operand: returns {mode, reg, lit, next}
    task automatic ref_opnd(input int code, input bit is_a,
                            output int mode, output int rg, output int lit, output int nxt);
        mode = 0; rg = 0; lit = 0; nxt = 0;
        if (code <= 7)       begin mode = 0; rg = code % 8; end
        else if (code <= 15) begin mode = 1; rg = code % 8; end
        else if (code <= 23) begin mode = 2; rg = code % 8; nxt = 1; end
        else if (code == 24) mode = is_a ? 4 : 3;
        else if (code == 25) mode = 5;
        else if (code == 26) begin mode = 6; nxt = 1; end
        else if (code == 27) mode = 7;
        else if (code == 28) mode = 8;
        else if (code == 29) mode = 9;
        else if (code == 30) begin mode = 10; nxt = 1; end
        else if (code == 31) begin mode = 11; nxt = 1; end
        else begin mode = 12; lit = (code - 33 + 65536) % 65536; end
    endtask

    function automatic string req_of_mode(int code, int mode);
        if (mode == 12) return "R9";
        if (code <= 7)  return "R2";
        if (code <= 15) return "R3";
        if (code <= 23) return "R4";
        if (code == 24) return "R5";
        if (code <= 26) return "R6";
        if (code <= 29) return "R7";
        return "R8";
    endfunction

    bit word_bad;
    task automatic fld(input string req, input string name, input int act, input int exp, input int w);
        if (act != exp) begin
            word_bad = 1;
            $display("FAIL %s word=%04h %s actual=%0d expected=%0d", req, w, name, act, exp);
        end
    endtask

    task automatic check_word(input int w);
        int opc, acode, bcode, am, ar, al, an, bm, br, bl, bn, sp, ln;
        opc = w % 32; bcode = (w / 32) % 32; acode = w / 1024;
        sp = (opc == 0);
        ref_opnd(acode, 1, am, ar, al, an);
        ref_opnd(bcode, 0, bm, br, bl, bn);
        if (sp) begin bm = 0; br = 0; bn = 0; end  // R12
        ln = 1 + an + bn;
        word_bad = 0;
        fld("R1", "opcode", int'(opcode), opc, w);
        fld("R1", "is_special", int'(is_special), sp, w);
        fld(req_of_mode(acode, am), "a_mode", int'(a_mode), am, w);
        fld("R10", "a_reg", int'(a_reg), ar, w);
        fld("R9", "a_lit", int'(a_lit), al, w);
        fld(req_of_mode(acode, am), "a_next", int'(a_next), an, w);
        fld(sp ? "R12" : req_of_mode(bcode, bm), "b_mode", int'(b_mode), bm, w);
        fld(sp ? "R12" : "R10", "b_reg", int'(b_reg), br, w);
        fld(sp ? "R12" : req_of_mode(bcode, bm), "b_next", int'(b_next), bn, w);
        fld("R11", "length", int'(length), ln, w);
        fld("R11", "cycles", int'(cycles), ln - 1, w);
        compared++;
        if (word_bad) mismatched++;
    endtask

    task automatic apply(input int w);
        @(posedge clk);
        instr_word = w[15:0];
        @(negedge clk);
        check_word(w);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1 start-up check: all-zero word is special, everything quiet
        apply(0);
        // directed corners: R5 push/pop, R9 literal ends, R11 three words, R12 special
        apply(16'h0301);   // b=0x18 push, opcode 1
        apply(16'h6001);   // a=0x18 pop
        apply(16'h8001);   // a=0x20 -> 0xffff (R9)
        apply(16'hFC01);   // a=0x3f -> 0x001e (R9)
        apply(16'h7BC1);   // a=0x1e, b=0x1e: length 3 (R11)
        apply(16'h43C0);   // special, b field 0x1e ignored (R12)
        // exhaustive sweep R1..R12
        for (int w = 0; w < 65536; w++) apply(w);
        done = 1;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        wait (done);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule